// File: doc/BRIEF.md
# Delay-Line Packet Slot Scheduler

This block is the timing controller of a slotted photonic packet switch whose only storage is a bank of fiber delay lines. At each slot strobe, any input may offer one packet with its target output port. For every offered packet, the scheduler chooses how many whole slots the packet waits (0 to B-1) and which delay-line group carries it. If no acceptable choice exists, it drops the packet.

Two circular calendars record future occupancy, one per output port and one per delay-line group. These keep departures from colliding at an output and at a second-stage group. A per input/output pair record of the last booked departure keeps each flow in arrival order.

Inputs are served one after another in a priority order that rotates every slot. Every grant is booked before the next input is evaluated, so packets offered in the same slot also see each other. Results appear, registered, in the cycle after the strobe.

Top module: `delay_slot_scheduler`

## Requirements
- R1: Each input that has in_valid set during a slot_tick cycle receives exactly one outcome in the next cycle: either gnt_valid or drop is set for that lane. Nothing is reported in any cycle that does not follow a strobe, and in_valid without slot_tick has no effect. Lane i's output port is in_dest[i*PW +: PW], its delay is gnt_delay[i*DW +: DW] and its group is gnt_group[i*GW +: GW], with PW = clog2(N), DW = clog2(B) and GW = clog2(G).
- R2: The granted delay is the smallest d in 0..B-1 that satisfies R3, R4 and R5 together.
- R3: No two granted packets leave toward the same output port in the same absolute slot, counted as strobe index plus delay.
- R4: At most G packets leave in any absolute slot, at most one on each delay-line group. The group granted is the lowest-numbered group that is free at the chosen delay.
- R5: A packet from input i to output o departs strictly after every earlier granted packet from i to o that is still pending.
- R6: The service pointer is 0 after reset and advances by one, modulo N, on each strobe. Within a slot, the input at the pointer is evaluated first and the rest follow in ascending order with wrap-around. Each input's grant is booked before the next input is evaluated.
- R7: A packet for which no delay in 0..B-1 works is dropped. drop_count then rises by the number of drops reported in that cycle.
- R8: Calendar entries free up once their slot has passed, and only strobes advance time. After B strobes with no packets, a lone packet gets delay 0 and group 0.
- R9: In reset and in the first cycle after it, every output is zero and all calendars are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_tick | input | 1 | Slot strobe; packets are taken and time advances |
| in_valid | input | N | Packet offered per input |
| in_dest | input | N*PW | Target output port per input |
| gnt_valid | output | N | Packet accepted, per input |
| gnt_delay | output | N*DW | Chosen delay in slots, per input |
| gnt_group | output | N*GW | Chosen delay-line group, per input |
| drop | output | N | Packet rejected, per input |
| drop_count | output | CW | Running count of rejected packets |

## Verification
On every cycle, the bound checker checks four things. Each offered packet gets exactly one outcome and silent cycles stay silent. Two same-slot grants to one output never share a delay. Two same-slot grants with equal delay never share a group. The drop counter tracks the reported drops.

Some properties span several slots and need a calendar model, so only the bench's scenarios can show them. These are the choice of the smallest delay, collisions with packets booked in earlier slots, flow ordering, the rotating service order, and the freeing of expired entries. The bench drives a single packet, a four-way fight for one output, a spread that exhausts the groups, saturation until drops occur, a long idle flush, unstrobed noise, and random traffic.

// File: rtl/dls_pkg.sv
package dls_pkg;

  // Modular add of two values already below m.
  function automatic int unsigned ring_add(int unsigned a, int unsigned b, int unsigned m);
    int unsigned s;
    s = a + b;
    return (s >= m) ? s - m : s;
  endfunction

  function automatic int unsigned idx_bits(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/dls_calendar.sv
module dls_calendar
  import dls_pkg::*;
#(
  parameter int N  = 4,
  parameter int B  = 8,
  parameter int G  = 2,
  parameter int PW = 2,
  parameter int DW = 3,
  parameter int GW = 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   tick,
  input  logic [N-1:0]           set_en,
  input  logic [N-1:0][DW-1:0]   set_dly,
  input  logic [N-1:0][PW-1:0]   set_out,
  input  logic [N-1:0][GW-1:0]   set_grp,
  output logic [B-1:0][N-1:0]    out_rel,
  output logic [B-1:0][G-1:0]    grp_rel
);

  logic [N-1:0]  ocal [B];
  logic [G-1:0]  gcal [B];
  logic [DW-1:0] base;
  logic [DW-1:0] row [N];

  // Physical calendar row of each booking.
  always_comb begin
    for (int i = 0; i < N; i++) begin
      row[i] = DW'(ring_add(int'(base), int'(set_dly[i]), B));
    end
  end

  // Relative view: entry d is the slot d strobes from now.
  always_comb begin
    for (int d = 0; d < B; d++) begin
      out_rel[d] = ocal[DW'(ring_add(int'(base), d, B))];
      grp_rel[d] = gcal[DW'(ring_add(int'(base), d, B))];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base <= '0;
      for (int r = 0; r < B; r++) begin
        ocal[r] <= '0;
        gcal[r] <= '0;
      end
    end else if (tick) begin
      for (int i = 0; i < N; i++) begin
        if (set_en[i]) begin
          ocal[row[i]][set_out[i]] <= 1'b1;
          gcal[row[i]][set_grp[i]] <= 1'b1;
        end
      end
      // The current slot departs now; its row is recycled.
      ocal[base] <= '0;
      gcal[base] <= '0;
      base <= (base == DW'(B - 1)) ? '0 : base + 1'b1;
    end
  end

endmodule

// File: rtl/dls_order_track.sv
module dls_order_track #(
  parameter int N  = 4,
  parameter int PW = 2,
  parameter int DW = 3
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         tick,
  input  logic [N-1:0]                 set_en,
  input  logic [N-1:0][DW-1:0]         set_dly,
  input  logic [N-1:0][PW-1:0]         set_out,
  output logic [N-1:0][N-1:0][DW-1:0]  min_dly
);

  // min_dly[i][o]: smallest delay a new packet of flow (i,o) may take,
  // i.e. one past the last booked departure, measured from now.
  always_ff @(posedge clk) begin
    for (int i = 0; i < N; i++) begin
      for (int o = 0; o < N; o++) begin
        if (rst) begin
          min_dly[i][o] <= '0;
        end else if (tick) begin
          if (set_en[i] && (set_out[i] == PW'(o))) begin
            min_dly[i][o] <= set_dly[i];
          end else if (min_dly[i][o] != '0) begin
            min_dly[i][o] <= min_dly[i][o] - 1'b1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/dls_picker.sv
module dls_picker
  import dls_pkg::*;
#(
  parameter int N  = 4,
  parameter int B  = 8,
  parameter int G  = 2,
  parameter int PW = 2,
  parameter int DW = 3,
  parameter int GW = 1
) (
  input  logic [PW-1:0]                rr,
  input  logic [N-1:0]                 valid,
  input  logic [N-1:0][PW-1:0]         dest,
  input  logic [N-1:0][N-1:0][DW-1:0]  min_dly,
  input  logic [B-1:0][N-1:0]          out_rel,
  input  logic [B-1:0][G-1:0]          grp_rel,
  output logic [N-1:0]                 pick_ok,
  output logic [N-1:0]                 pick_drop,
  output logic [N-1:0][DW-1:0]         pick_dly,
  output logic [N-1:0][GW-1:0]         pick_grp
);

  logic [B-1:0][N-1:0] oc;
  logic [B-1:0][G-1:0] gc;
  logic [PW-1:0]       idx;
  logic                hit;
  logic [DW-1:0]       hd;
  logic [GW-1:0]       hg;

  // Serial evaluation in rotated order; each booking is visible to later inputs.
  always_comb begin
    oc        = out_rel;
    gc        = grp_rel;
    pick_ok   = '0;
    pick_drop = '0;
    pick_dly  = '0;
    pick_grp  = '0;
    idx       = '0;
    hit       = 1'b0;
    hd        = '0;
    hg        = '0;
    for (int k = 0; k < N; k++) begin
      idx = PW'(ring_add(int'(rr), k, N));
      hit = 1'b0;
      hd  = '0;
      hg  = '0;
      if (valid[idx]) begin
        for (int d = 0; d < B; d++) begin
          for (int g = 0; g < G; g++) begin
            if (!hit && !oc[d][dest[idx]] && !gc[d][g] &&
                (d >= int'(min_dly[idx][dest[idx]]))) begin
              hit = 1'b1;
              hd  = DW'(d);
              hg  = GW'(g);
            end
          end
        end
        if (hit) begin
          oc[hd][dest[idx]] = 1'b1;
          gc[hd][hg]        = 1'b1;
          pick_ok[idx]      = 1'b1;
          pick_dly[idx]     = hd;
          pick_grp[idx]     = hg;
        end else begin
          pick_drop[idx]    = 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/delay_slot_scheduler.sv
module delay_slot_scheduler
  import dls_pkg::*;
#(
  parameter int N  = 4,
  parameter int B  = 8,
  parameter int G  = 2,
  parameter int CW = 16,
  localparam int PW = idx_bits(N),
  localparam int DW = idx_bits(B),
  localparam int GW = idx_bits(G)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            slot_tick,
  input  logic [N-1:0]    in_valid,
  input  logic [N*PW-1:0] in_dest,
  output logic [N-1:0]    gnt_valid,
  output logic [N*DW-1:0] gnt_delay,
  output logic [N*GW-1:0] gnt_group,
  output logic [N-1:0]    drop,
  output logic [CW-1:0]   drop_count
);

  logic [N-1:0][PW-1:0]        dest_a;
  logic [N-1:0]                valid_eff;
  logic [PW-1:0]               rr;
  logic [N-1:0][N-1:0][DW-1:0] min_dly;
  logic [B-1:0][N-1:0]         out_rel;
  logic [B-1:0][G-1:0]         grp_rel;
  logic [N-1:0]                pick_ok;
  logic [N-1:0]                pick_drop;
  logic [N-1:0][DW-1:0]        pick_dly;
  logic [N-1:0][GW-1:0]        pick_grp;

  assign dest_a    = in_dest;
  assign valid_eff = in_valid & {N{slot_tick}};

  dls_picker #(.N(N), .B(B), .G(G), .PW(PW), .DW(DW), .GW(GW)) u_pick (
    .rr        (rr),
    .valid     (valid_eff),
    .dest      (dest_a),
    .min_dly   (min_dly),
    .out_rel   (out_rel),
    .grp_rel   (grp_rel),
    .pick_ok   (pick_ok),
    .pick_drop (pick_drop),
    .pick_dly  (pick_dly),
    .pick_grp  (pick_grp)
  );

  dls_calendar #(.N(N), .B(B), .G(G), .PW(PW), .DW(DW), .GW(GW)) u_cal (
    .clk     (clk),
    .rst     (rst),
    .tick    (slot_tick),
    .set_en  (pick_ok),
    .set_dly (pick_dly),
    .set_out (dest_a),
    .set_grp (pick_grp),
    .out_rel (out_rel),
    .grp_rel (grp_rel)
  );

  dls_order_track #(.N(N), .PW(PW), .DW(DW)) u_ord (
    .clk     (clk),
    .rst     (rst),
    .tick    (slot_tick),
    .set_en  (pick_ok),
    .set_dly (pick_dly),
    .set_out (dest_a),
    .min_dly (min_dly)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rr         <= '0;
      gnt_valid  <= '0;
      gnt_delay  <= '0;
      gnt_group  <= '0;
      drop       <= '0;
      drop_count <= '0;
    end else begin
      gnt_valid  <= pick_ok;
      gnt_delay  <= pick_dly;
      gnt_group  <= pick_grp;
      drop       <= pick_drop;
      drop_count <= drop_count + CW'($countones(pick_drop));
      if (slot_tick) begin
        rr <= (rr == PW'(N - 1)) ? '0 : rr + 1'b1;
      end
    end
  end

endmodule

// File: rtl/delay_slot_scheduler_chk.sv
module delay_slot_scheduler_chk
  import dls_pkg::*;
#(
  parameter int N  = 4,
  parameter int B  = 8,
  parameter int G  = 2,
  parameter int CW = 16,
  localparam int PW = idx_bits(N),
  localparam int DW = idx_bits(B),
  localparam int GW = idx_bits(G)
) (
  input logic            clk,
  input logic            rst,
  input logic            slot_tick,
  input logic [N-1:0]    in_valid,
  input logic [N*PW-1:0] in_dest,
  input logic [N-1:0]    gnt_valid,
  input logic [N*DW-1:0] gnt_delay,
  input logic [N*GW-1:0] gnt_group,
  input logic [N-1:0]    drop,
  input logic [CW-1:0]   drop_count
);

  logic            seen_tick;
  logic [N-1:0]    seen_valid;
  logic [N*PW-1:0] seen_dest;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_tick  <= 1'b0;
      seen_valid <= '0;
      seen_dest  <= '0;
    end else begin
      seen_tick  <= slot_tick;
      seen_valid <= in_valid;
      seen_dest  <= in_dest;
    end
  end

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
    (gnt_valid | drop) == (seen_valid & {N{seen_tick}})); // R1

  AST_NO_DOUBLE: assert property (@(posedge clk) disable iff (rst)
    (gnt_valid & drop) == '0); // R1

  AST_DROP_TALLY: assert property (@(posedge clk) disable iff (rst)
    drop_count == CW'($past(drop_count) + CW'($countones(drop)))); // R7

  always_ff @(posedge clk) begin
    if (!rst) begin
      for (int i = 0; i < N; i++) begin
        for (int j = i + 1; j < N; j++) begin
          if (gnt_valid[i] && gnt_valid[j]) begin
            if (seen_dest[i*PW +: PW] == seen_dest[j*PW +: PW]) begin
              AST_OUT_DISTINCT: assert (gnt_delay[i*DW +: DW] != gnt_delay[j*DW +: DW])
                else $error("output clash"); // R3
            end
            if (gnt_delay[i*DW +: DW] == gnt_delay[j*DW +: DW]) begin
              AST_GRP_DISTINCT: assert (gnt_group[i*GW +: GW] != gnt_group[j*GW +: GW])
                else $error("group clash"); // R4
            end
          end
        end
      end
    end
  end

endmodule

bind delay_slot_scheduler delay_slot_scheduler_chk #(.N(N), .B(B), .G(G), .CW(CW)) u_chk (.*);

// File: tb/delay_slot_scheduler_test.sv
`timescale 1ns/1ps
module delay_slot_scheduler_test;

  localparam int N  = 4;
  localparam int B  = 8;
  localparam int G  = 2;
  localparam int CW = 16;
  localparam int PW = 2;
  localparam int DW = 3;
  localparam int GW = 1;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            slot_tick = 1'b0;
  logic [N-1:0]    in_valid = '0;
  logic [N*PW-1:0] in_dest = '0;
  logic [N-1:0]    gnt_valid;
  logic [N*DW-1:0] gnt_delay;
  logic [N*GW-1:0] gnt_group;
  logic [N-1:0]    drop;
  logic [CW-1:0]   drop_count;

  always #10 clk = ~clk;

  delay_slot_scheduler #(.N(N), .B(B), .G(G), .CW(CW)) uut (
    .clk(clk), .rst(rst), .slot_tick(slot_tick), .in_valid(in_valid),
    .in_dest(in_dest), .gnt_valid(gnt_valid), .gnt_delay(gnt_delay),
    .gnt_group(gnt_group), .drop(drop), .drop_count(drop_count)
  );

  typedef struct packed {
    logic [N-1:0]         g;
    logic [N-1:0]         dr;
    logic [N-1:0][DW-1:0] dly;
    logic [N-1:0][GW-1:0] grp;
    logic [31:0]          dcnt;
  } exp_t;

  exp_t  q[$];
  string tq[$];
  int    checks = 0;
  int    failures = 0;
  logic  seen_t = 1'b0;
  logic  done = 1'b0;

  // Reference calendars in absolute slot numbers.
  bit [N-1:0] ocal [256];
  bit [G-1:0] gcal [256];
  int last_dep [N][N];
  int cur = 0;
  int rr_m = 0;
  int dcnt_m = 0;

  task automatic run_slot(input logic [N-1:0] v, input logic [N*PW-1:0] dst, input string tag);
    exp_t e;
    e = '0;
    for (int k = 0; k < N; k++) begin
      int i;
      int o;
      bit hit;
      int hd;
      int hg;
      i = (rr_m + k) % N;
      if (v[i]) begin
        o = int'(dst[i*PW +: PW]);
        hit = 0; hd = 0; hg = 0;
        for (int d = 0; d < B; d++) begin
          for (int g = 0; g < G; g++) begin
            int t;
            t = (cur + d) % 256;
            if (!hit && !ocal[t][o] && !gcal[t][g] && (cur + d > last_dep[i][o])) begin
              hit = 1; hd = d; hg = g;
            end
          end
        end
        if (hit) begin
          ocal[(cur + hd) % 256][o] = 1'b1;
          gcal[(cur + hd) % 256][hg] = 1'b1;
          last_dep[i][o] = cur + hd;
          e.g[i] = 1'b1;
          e.dly[i] = DW'(hd);
          e.grp[i] = GW'(hg);
        end else begin
          e.dr[i] = 1'b1;
          dcnt_m++;
        end
      end
    end
    e.dcnt = dcnt_m;
    q.push_back(e);
    tq.push_back(tag);
    ocal[cur % 256] = '0;
    gcal[cur % 256] = '0;
    cur++;
    rr_m = (rr_m + 1) % N;
    @(negedge clk);
    slot_tick = 1'b1;
    in_valid = v;
    in_dest = dst;
    @(negedge clk);
    slot_tick = 1'b0;
    in_valid = '0;
  endtask

  // Monitor: pops one expected item per strobe, checks silence otherwise.
  always @(posedge clk) seen_t <= slot_tick;

  always @(negedge clk) begin
    if (!rst && !done) begin
      if (seen_t) begin
        if (q.size() == 0) begin
          checks++; failures++;
          $display("FAIL R1 result with no expected item");
        end else begin
          exp_t  e;
          string tg;
          e = q.pop_front();
          tg = tq.pop_front();
          for (int i = 0; i < N; i++) begin
            checks++;
            if (gnt_valid[i] !== e.g[i] || drop[i] !== e.dr[i] ||
                (e.g[i] && (gnt_delay[i*DW +: DW] !== e.dly[i] || gnt_group[i*GW +: GW] !== e.grp[i]))) begin
              failures++;
              $display("FAIL %s lane %0d: got g=%b dr=%b dly=%0d grp=%0d exp g=%b dr=%b dly=%0d grp=%0d",
                       tg, i, gnt_valid[i], drop[i], gnt_delay[i*DW +: DW], gnt_group[i*GW +: GW],
                       e.g[i], e.dr[i], e.dly[i], e.grp[i]);
            end
          end
          checks++;
          if (drop_count !== e.dcnt[CW-1:0]) begin
            failures++;
            $display("FAIL R7 drop_count got %0d exp %0d", drop_count, e.dcnt);
          end
        end
      end else begin
        checks++;
        if (gnt_valid !== '0 || drop !== '0) begin
          failures++;
          $display("FAIL R1 output without strobe got g=%b dr=%b exp 0", gnt_valid, drop);
        end
      end
    end
  end

  task automatic idle_slots(input int n, input string tag);
    for (int s = 0; s < n; s++) run_slot('0, '0, tag);
  endtask

  initial begin
    for (int i = 0; i < N; i++)
      for (int o = 0; o < N; o++) last_dep[i][o] = -1;
    for (int t = 0; t < 256; t++) begin
      ocal[t] = '0;
      gcal[t] = '0;
    end
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9: quiet outputs after reset
    checks++;
    if (gnt_valid !== '0 || drop !== '0 || drop_count !== '0 || gnt_delay !== '0) begin
      failures++;
      $display("FAIL R9 reset state g=%b dr=%b cnt=%0d exp all zero", gnt_valid, drop, drop_count);
    end
    // R2 / R8: lone packet on empty calendars -> delay 0, group 0
    run_slot(4'b0001, 8'b00_00_01_00, "R2");
    // R3 R6: four inputs fight for output 0
    idle_slots(B, "R8");
    run_slot(4'b1111, 8'b00_00_00_00, "R3 R6");
    idle_slots(B, "R8");
    run_slot(4'b1111, 8'b00_00_00_00, "R6");
    // R4: distinct outputs exhaust groups
    idle_slots(B, "R8");
    run_slot(4'b1111, 8'b11_10_01_00, "R4");
    // R7: saturate output 2 until drops appear
    idle_slots(B, "R8");
    run_slot(4'b1111, 8'b10_10_10_10, "R7");
    run_slot(4'b1111, 8'b10_10_10_10, "R7");
    run_slot(4'b1111, 8'b10_10_10_10, "R7");
    run_slot(4'b1111, 8'b10_10_10_10, "R7");
    // R1: offered packets without a strobe are ignored
    idle_slots(B, "R8");
    @(negedge clk);
    in_valid = 4'b1111;
    in_dest = 8'b01_01_01_01;
    repeat (3) @(negedge clk);
    in_valid = '0;
    run_slot(4'b0100, 8'b00_01_00_00, "R1 R8");
    // R5 R2: random traffic
    for (int s = 0; s < 300; s++) begin
      logic [N-1:0]    v;
      logic [N*PW-1:0] dd;
      v = N'($urandom);
      dd = (N*PW)'($urandom);
      if ((s % 37) == 36) v = '0;
      run_slot(v, dd, "R5 R2");
    end
    repeat (3) @(negedge clk);
    done = 1'b1;
    checks++;
    if (q.size() != 0) begin
      failures++;
      $display("FAIL R1 %0d results missing exp 0", q.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL R1 watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule